// File: doc/BRIEF.md
# Subnormal-Operand Single-Precision Multiplier

This unit computes the product of two single-precision floating-point words when the arithmetic pipeline of a host core refuses to handle a subnormal input. The caller puts the subnormal operand in `op_a_i` and the other operand in `op_b_i`, raises `start_i` for one cycle, and later sees `done_o` pulse with the packed product on `result_o`.

The operand B fraction gets its hidden one. The operand A fraction is used as it is, with no hidden bit. The unit registers the product of the two. A shifter then walks a copy of that product towards zero one bit per cycle to find the index `w` of its leading one. From `w` and the biased exponent of operand B the unit forms the working exponent `e = expB + w - 172`. The result is packed as a normal, a subnormal or a zero. Bits below the kept fraction are dropped, so no rounding ever takes place. Infinity and NaN operands, exception flags and double precision are not handled.

Top module: `dnm_fmul`

## Requirements
- R1: While and after reset (`rst_ni` low), `done_o` is 0 and `result_o` is 32'h0000_0000.
- R2: The result is a zero carrying the sign of R6 in three cases: operand B has a zero exponent field (bits 30:23), operand A has zero magnitude (bits 30:0), or the fraction product is zero.
- R3: When `e > 0`, the result holds `e` in bits 30:23. Bits 22:0 hold bits 22:0 of the product shifted right by `w-23`, truncated and not rounded.
- R4: When `-22 <= e <= 0`, the exponent field is 0. Bits 22:0 hold bits 22:0 of the product shifted right by `w-22-e`.
- R5: When `e < -22`, the magnitude bits 30:0 of the result are zero.
- R6: Bit 31 of every result is the XOR of bit 31 of the two operands.
- R7: `done_o` is high for exactly one cycle. For an accepted start it is high after clock edge number `w+3`, counted from the edge that sampled `start_i` (edge 0). For the zero cases of R2 it is high after edge 2.
- R8: A start is accepted only when no operation is in flight. A start sampled on any edge before that operation's done edge is ignored. A start in the cycle where `done_o` is high is accepted.
- R9: `result_o` changes only together with a `done_o` pulse, and holds its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, one cycle |
| op_a_i | input | 32 | Operand A, the subnormal one |
| op_b_i | input | 32 | Operand B |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Packed product, held between completions |

## Verification
Two events can fall in the same cycle: a completion, and the acceptance of the next start. A start can also arrive on the packing edge, one cycle before the unit is free. The bench issues each new operation in the very cycle where it predicts `done_o`, so the second start overlaps the first completion. It also fires starts three cycles into a running operation and drops starts onto the packing edge. A cycle-level model in the bench judges each of these: it knows when the unit is busy, it ignores starts then, and it compares `done_o` and `result_o` against its own prediction on every clock.

// File: rtl/dnm_fmul_pkg.sv
package dnm_fmul_pkg;
  localparam int unsigned DEF_FRAC_W = 23;
  localparam int unsigned DEF_EXP_W  = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_PACK = 2'd2
  } state_e;
endpackage

// File: rtl/dnm_fmul_front.sv
module dnm_fmul_front #(
  parameter int unsigned FRAC_W = 23,
  parameter int unsigned EXP_W  = 8,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W,
  localparam int unsigned PROD_W = 2 * FRAC_W + 1
) (
  input  logic [WORD_W-1:0] op_a_i,
  input  logic [WORD_W-1:0] op_b_i,
  output logic              zero_o,
  output logic              sign_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic [PROD_W-1:0] prod_o
);
  logic [FRAC_W:0] frac_b;

  // B below smallest normal, or A exactly zero -> signed zero
  assign zero_o = (op_b_i[WORD_W-2:FRAC_W] == '0) || (op_a_i[WORD_W-2:0] == '0);
  assign sign_o = op_a_i[WORD_W-1] ^ op_b_i[WORD_W-1];
  assign exp_o  = op_b_i[WORD_W-2:FRAC_W];
  assign frac_b = {1'b1, op_b_i[FRAC_W-1:0]};
  assign prod_o = PROD_W'(op_a_i[FRAC_W-1:0]) * PROD_W'(frac_b);
endmodule

// File: rtl/dnm_fmul_scan.sv
module dnm_fmul_scan #(
  parameter int unsigned W = 47,
  localparam int unsigned CNT_W = $clog2(W + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [W-1:0]     load_val_i,
  input  logic             run_i,
  output logic             empty_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [W-1:0]     copy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      copy_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      copy_q <= load_val_i;
      cnt_q  <= '0;
    end else if (run_i && (copy_q != '0)) begin
      copy_q <= copy_q >> 1;
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign empty_o = (copy_q == '0);
  assign cnt_o   = cnt_q;  // shifts taken = msb index + 1
endmodule

// File: rtl/dnm_fmul_pack.sv
module dnm_fmul_pack #(
  parameter int unsigned FRAC_W = 23,
  parameter int unsigned EXP_W  = 8,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W,
  localparam int unsigned PROD_W = 2 * FRAC_W + 1,
  localparam int unsigned CNT_W  = $clog2(PROD_W + 2),
  localparam int          BIAS_M1 = (1 << (EXP_W - 1)) - 2
) (
  input  logic [PROD_W-1:0] prod_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic              sign_i,
  input  logic              zero_i,
  output logic [WORD_W-1:0] word_o
);
  int                w;
  int                e;
  int                sh;
  logic [PROD_W-1:0] shifted;

  always_comb begin
    w       = int'(cnt_i) - 1;
    e       = int'(exp_i) + w - BIAS_M1 - 2 * int'(FRAC_W);
    sh      = 0;
    shifted = '0;
    word_o  = '0;
    word_o[WORD_W-1] = sign_i;
    if (!zero_i && (cnt_i != '0)) begin
      if (e > 0) begin
        sh      = w - int'(FRAC_W);
        shifted = prod_i >> sh;
        word_o[WORD_W-2:FRAC_W] = e[EXP_W-1:0];
        word_o[FRAC_W-1:0]      = shifted[FRAC_W-1:0];
      end else if (e + int'(FRAC_W) - 1 >= 0) begin
        sh      = w - (int'(FRAC_W) - 1) - e;
        shifted = prod_i >> sh;
        word_o[FRAC_W-1:0] = shifted[FRAC_W-1:0];
      end
    end
  end
endmodule

// File: rtl/dnm_fmul.sv
module dnm_fmul
  import dnm_fmul_pkg::*;
#(
  parameter int unsigned FRAC_W = DEF_FRAC_W,
  parameter int unsigned EXP_W  = DEF_EXP_W,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W,
  localparam int unsigned PROD_W = 2 * FRAC_W + 1,
  localparam int unsigned CNT_W  = $clog2(PROD_W + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] op_a_i,
  input  logic [WORD_W-1:0] op_b_i,
  output logic              done_o,
  output logic [WORD_W-1:0] result_o
);
  state_e            state_q;
  logic [PROD_W-1:0] prod_q;
  logic [EXP_W-1:0]  exp_q;
  logic              sign_q;
  logic              zero_q;
  logic              done_q;
  logic [WORD_W-1:0] result_q;

  logic              f_zero;
  logic              f_sign;
  logic [EXP_W-1:0]  f_exp;
  logic [PROD_W-1:0] f_prod;
  logic              accept;
  logic              scan_empty;
  logic [CNT_W-1:0]  scan_cnt;
  logic [WORD_W-1:0] pack_word;

  assign accept = (state_q == ST_IDLE) && start_i;

  dnm_fmul_front #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) front_i (
    .op_a_i (op_a_i),
    .op_b_i (op_b_i),
    .zero_o (f_zero),
    .sign_o (f_sign),
    .exp_o  (f_exp),
    .prod_o (f_prod)
  );

  dnm_fmul_scan #(.W(PROD_W)) scan_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_val_i (f_zero ? '0 : f_prod),
    .run_i      (state_q == ST_SCAN),
    .empty_o    (scan_empty),
    .cnt_o      (scan_cnt)
  );

  dnm_fmul_pack #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) pack_i (
    .prod_i (prod_q),
    .cnt_i  (scan_cnt),
    .exp_i  (exp_q),
    .sign_i (sign_q),
    .zero_i (zero_q),
    .word_o (pack_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      prod_q   <= '0;
      exp_q    <= '0;
      sign_q   <= 1'b0;
      zero_q   <= 1'b0;
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          prod_q  <= f_prod;
          exp_q   <= f_exp;
          sign_q  <= f_sign;
          zero_q  <= f_zero;
          state_q <= ST_SCAN;
        end
        ST_SCAN: if (scan_empty) state_q <= ST_PACK;
        ST_PACK: begin
          result_q <= pack_word;
          done_q   <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o   = done_q;
  assign result_o = result_q;
endmodule

// File: rtl/dnm_fmul_chk.sv
module dnm_fmul_chk
  import dnm_fmul_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              done_o,
  input logic [WORD_W-1:0] result_o,
  input state_e            state_q,
  input logic              sign_q,
  input logic              zero_q
);
  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_done_after_pack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(state_q) == ST_PACK);

  a_r8_pack_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PACK) |=> (state_q == ST_IDLE));

  a_r8_busy_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SCAN && start_i) |=> ($stable(sign_q) && $stable(zero_q)));

  a_r6_sign_xor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> result_o[WORD_W-1] == sign_q);

  a_r2_zero_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && zero_q) |-> result_o[WORD_W-2:0] == '0);

  a_r9_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> done_o);
endmodule

bind dnm_fmul dnm_fmul_chk #(.WORD_W(WORD_W)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .done_o   (done_o),
  .result_o (result_o),
  .state_q  (state_q),
  .sign_q   (sign_q),
  .zero_q   (zero_q)
);

// File: tb/dnm_fmul_tb_top.sv
`timescale 1ns/1ps
module dnm_fmul_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] op_a_i = '0;
  logic [31:0] op_b_i = '0;
  logic        done_o;
  logic [31:0] result_o;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  dnm_fmul dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .op_a_i(op_a_i), .op_b_i(op_b_i), .done_o(done_o), .result_o(result_o)
  );

  // Reference of the truncating algorithm; tag names the governing requirement
  function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b,
                                          output int lat, output string tag);
    longint unsigned ia, ib, fa, fb, m, n;
    longint e, w, ex;
    logic [31:0] s;
    ia = longint'(a & 32'h7fff_ffff);
    ib = longint'(b & 32'h7fff_ffff);
    s  = (a ^ b) & 32'h8000_0000;
    lat = 2;
    tag = "R2";
    if (ib < 64'h0080_0000 || ia == 0) return s;
    ex = longint'(ib >> 23);
    fa = ia & 64'h007f_ffff;
    fb = (ib & 64'h007f_ffff) | 64'h0080_0000;
    m  = fa * fb;
    if (m == 0) return s;
    n = m; w = -1;
    while (n != 0) begin n = n >> 1; w++; end
    lat = int'(w) + 3;
    e = ex + w - 172;
    if (e > 0) begin
      tag = "R3";
      return s | 32'((m >> (w - 23)) & 64'h007f_ffff) | 32'(e << 23);
    end else if (e + 22 >= 0) begin
      tag = "R4";
      return s | 32'((m >> (w - 22 - e)) & 64'h007f_ffff);
    end
    tag = "R5";
    return s;
  endfunction

  // Cycle-level model
  int          rem = 0;
  logic        m_done = 1'b0;
  logic [31:0] m_res = '0;
  logic [31:0] pend = '0;
  string       pend_tag = "R2";
  string       m_tag = "R1";

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem <= 0; m_done <= 1'b0; m_res <= '0; m_tag <= "R1";
    end else begin
      m_done <= 1'b0;
      if (rem > 0) begin  // R8: starts ignored while in flight
        if (rem == 1) begin m_done <= 1'b1; m_res <= pend; m_tag <= pend_tag; end
        rem <= rem - 1;
      end else if (start_i) begin
        int l; string t; logic [31:0] r;
        r = ref_mul(op_a_i, op_b_i, l, t);
        pend <= r; pend_tag <= t; rem <= l;
      end
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      tests++;
      if (done_o !== m_done) begin
        fails++;
        $display("FAIL R7 done_o act=%b exp=%b t=%0t", done_o, m_done, $time);
      end
      tests++;
      if (result_o !== m_res) begin
        fails++;
        $display("FAIL %s/R6/R9 result_o act=%h exp=%h t=%0t", m_tag, result_o, m_res, $time);
      end
    end
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic issue(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk_i);
    op_a_i = a; op_b_i = b; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (rem != 0) @(negedge clk_i);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  initial begin
    logic [31:0] a, b, r1;
    int l; string t;
    repeat (3) @(negedge clk_i);
    chk("R1 done", {31'b0, done_o}, 32'h0);
    chk("R1 result", result_o, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after release", result_o, 32'h0);

    // R2: zero-class operands, both signs
    issue(32'h8000_0001, 32'h0000_0005); wait_idle(); @(negedge clk_i);
    chk("R2 B subnormal", result_o, 32'h8000_0000);
    issue(32'h8000_0000, 32'h3f80_0000); wait_idle(); @(negedge clk_i);
    chk("R2 A zero", result_o, 32'h8000_0000);
    issue(32'h3f80_0000, 32'hbf80_0000); wait_idle(); @(negedge clk_i);
    chk("R2 zero product", result_o, 32'h8000_0000);
    // R3 normal result
    issue(32'h0040_0000, 32'h4000_0000); wait_idle(); @(negedge clk_i);
    chk("R3 normal", result_o, 32'h0080_0000);
    // R4 subnormal result, R6 sign
    issue(32'h0040_0000, 32'hbf80_0000); wait_idle(); @(negedge clk_i);
    chk("R4/R6 subnormal", result_o, 32'h8040_0000);
    // R5 underflow
    issue(32'h0000_0001, 32'h0080_0000); wait_idle(); @(negedge clk_i);
    chk("R5 underflow", result_o, 32'h0000_0000);

    // R8: start mid-operation is ignored
    a = 32'h0012_3456; b = 32'h4b00_1234;
    r1 = ref_mul(a, b, l, t);
    issue(a, b);
    repeat (2) @(negedge clk_i);
    issue(32'h8000_0001, 32'h0000_0001);
    wait_idle(); @(negedge clk_i);
    chk("R8 busy start ignored", result_o, r1);
    repeat (4) @(negedge clk_i);
    chk("R9 result held", result_o, r1);

    // R8: start on the packing edge, then start in the done cycle
    issue(32'h0000_0fff, 32'h4280_0000);
    while (rem != 1) @(negedge clk_i);
    op_a_i = 32'h0000_0003; op_b_i = 32'h3f80_0000; start_i = 1'b1;
    @(negedge clk_i);  // done cycle, start still high -> accepted
    @(negedge clk_i);
    start_i = 1'b0;
    wait_idle(); @(negedge clk_i);

    // Random, with back-to-back starts in the done cycle
    for (int i = 0; i < 400; i++) begin
      a = {$urandom_range(1, 0) == 1, 8'h00, 23'($urandom)};
      b = {$urandom_range(1, 0) == 1, 8'($urandom_range(254, 1)), 23'($urandom)};
      if ((i % 3) == 0) begin
        while (rem > 1) @(negedge clk_i);
        if (rem == 1) @(negedge clk_i);
        op_a_i = a; op_b_i = b; start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
      end else begin
        wait_idle();
        issue(a, b);
      end
    end
    wait_idle();
    repeat (3) @(negedge clk_i);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule